// File: doc/BRIEF.md
# Multi-Event Circular Acquisition Buffer

This block manages a sample memory that is cut into a programmable number of equal event slots. A stream of samples is written without pause into the active slot, which wraps around like a ring. When a trigger is accepted, the block keeps writing a programmable number of further samples. It then freezes the slot, together with the offset of its oldest sample, and switches to the next slot in the same cycle. No sample is lost in the switch.

A separate read port drains frozen slots strictly in the order they were frozen. Each slot is read from its oldest sample to its newest, and the read side runs independently of the writer. A slot becomes writable again only after its last word has been read. When every slot holds an unread event, the block raises a full flag, drops incoming samples and ignores triggers until a slot is released. The slot count and post-trigger length are configuration inputs. They are held stable while the block runs and are changed only under reset.

Top module: `acq_event_buffer`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `occupancy` is 0 and `rd_valid` is 0.
- R2: Reading a frozen slot returns the most recent slot-size samples that were accepted into it, oldest first and ending with the freeze sample. Positions older than the number of samples written since the slot became active hold undefined data.
- R3: A trigger accepted in a cycle makes that cycle's sample the last pre-trigger sample. The slot freezes in the cycle that writes the `cfg_post_len`-th further valid sample. With a length of 0, it freezes in the trigger cycle itself, and `occupancy` shows the new event right after that edge.
- R4: The first valid sample after a freeze is written at offset 0 of the next slot, so consecutive events leave no gap in the stream.
- R5: The memory of 2^ADDR_W words forms 2^`cfg_slots_log2` slots of 2^(ADDR_W-`cfg_slots_log2`) words each. Slots are read in the order they were frozen.
- R6: Each `rd_en` accepted while not empty yields exactly one word, with `rd_valid` high in the next cycle. `rd_last` is high only with the final word of a slot.
- R7: `rd_en` while `empty` is 1 is ignored: no `rd_valid` follows and the read position does not move.
- R8: A trigger that arrives while a post-trigger count is running is ignored and does not restart the count.
- R9: When `occupancy` equals the slot count, `full` is 1, samples are not stored and triggers are ignored. After a slot is released, acquisition resumes at offset 0 of that slot.
- R10: A slot is released only when its last word is read; `occupancy` drops by one at that edge and not earlier.
- R11: `occupancy` reports the number of frozen, not fully read slots and never exceeds the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slots_log2 | input | $clog2(SLOTS_LOG2_MAX+1) | Base-2 log of the slot count |
| cfg_post_len | input | ADDR_W | Number of samples stored after the trigger sample |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample value |
| trig | input | 1 | Trigger request |
| rd_en | input | 1 | Read one word from the oldest frozen slot |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_data | output | DATA_W | Word read |
| rd_last | output | 1 | Word is the final one of its slot |
| full | output | 1 | Every slot holds an unread event |
| empty | output | 1 | No frozen slot is waiting |
| occupancy | output | SLOTS_LOG2_MAX+1 | Count of frozen, unread slots |

## Verification
The assertions check the following properties on every cycle:
- the occupancy bound and its one-step changes;
- that no freeze happens while full and no release happens while empty;
- that a running post-trigger count stays nonzero, is not restarted by a second trigger and always leads to offset 0 of a fresh slot;
- that the read position rests at the start of a slot while empty.

Only the bench scenarios can show the content and order of each window against a reference of the stream. This covers the exact freeze sample for zero and nonzero post lengths, the placement of the first post-freeze sample, the data stored after a full period, and the slot geometry for different slot counts.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic {
        WR_PRE  = 1'b0,
        WR_POST = 1'b1
    } acq_wr_state_e;

    typedef struct packed {
        logic valid;
        logic last;
    } acq_rd_flag_t;

endpackage

// File: rtl/acq_sample_ram.sv
module acq_sample_ram #(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/acq_wr_ctrl.sv
module acq_wr_ctrl
    import acq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SLOT_W  = 3,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic               trig,
    input  logic               full,
    input  logic [ADDR_W-1:0]  post_len,
    input  logic [ADDR_W-1:0]  off_mask,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [SLOT_W-1:0]  wr_slot,
    output logic               ram_we,
    output logic [ADDR_W-1:0]  ram_waddr,
    output logic               freeze,
    output logic [ADDR_W-1:0]  freeze_off
);
    acq_wr_state_e     state_q;
    logic [ADDR_W-1:0] wptr_q;
    logic [ADDR_W-1:0] cnt_q;
    logic [ADDR_W-1:0] wptr_nx;
    logic              wr_go;
    logic              trig_ok;

    always_comb begin
        wr_go   = smp_valid && !full;
        wptr_nx = wr_go ? ((wptr_q + ADDR_W'(1)) & off_mask) : wptr_q;
        trig_ok = (state_q == WR_PRE) && trig && !full;
        freeze  = (trig_ok && (post_len == '0))
               || ((state_q == WR_POST) && wr_go && (cnt_q == ADDR_W'(1)));
    end

    assign ram_we     = wr_go;
    assign ram_waddr  = (ADDR_W'(wr_slot) << shift) | wptr_q;
    assign freeze_off = wptr_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_PRE;
            wptr_q  <= '0;
            cnt_q   <= '0;
        end else if (freeze) begin
            state_q <= WR_PRE;
            wptr_q  <= '0;
            cnt_q   <= '0;
        end else begin
            wptr_q <= wptr_nx;
            if (trig_ok) begin
                state_q <= WR_POST;
                cnt_q   <= post_len;
            end else if ((state_q == WR_POST) && wr_go) begin
                cnt_q <= cnt_q - ADDR_W'(1);
            end
        end
    end

    // R3: a running post-trigger count is never zero
    assert_post_count_live_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == WR_POST) |-> (cnt_q != '0));

    // R8: a second trigger neither restarts nor lengthens the count
    assert_retrigger_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == WR_POST) && trig && !freeze)
        |=> ((state_q == WR_POST) && (cnt_q <= $past(cnt_q))));

    // R4: the sample after a freeze lands at offset 0
    assert_fresh_slot_R4: assert property (@(posedge clk) disable iff (rst)
        freeze |=> (wptr_q == '0));

    // R9: while full, the writer stays idle
    assert_idle_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        (full && (state_q == WR_PRE)) |=> (state_q == WR_PRE));
endmodule

// File: rtl/acq_slot_ring.sv
module acq_slot_ring #(
    parameter int ADDR_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W:0]   n_slots,
    input  logic [SLOT_W-1:0] slot_mask,
    input  logic              freeze,
    input  logic [ADDR_W-1:0] freeze_off,
    input  logic              slot_done,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [ADDR_W-1:0] rd_start,
    output logic [SLOT_W:0]   occ,
    output logic              full,
    output logic              empty
);
    localparam int NSLOT = 1 << SLOT_W;

    logic [SLOT_W-1:0] wr_slot_q;
    logic [SLOT_W-1:0] rd_slot_q;
    logic [SLOT_W:0]   occ_q;
    logic [ADDR_W-1:0] start_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_start
        always_ff @(posedge clk) begin
            if (rst)
                start_q[g] <= '0;
            else if (freeze && (wr_slot_q == SLOT_W'(g)))
                start_q[g] <= freeze_off;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_slot_q <= '0;
            rd_slot_q <= '0;
            occ_q     <= '0;
        end else begin
            if (freeze)    wr_slot_q <= (wr_slot_q + SLOT_W'(1)) & slot_mask;
            if (slot_done) rd_slot_q <= (rd_slot_q + SLOT_W'(1)) & slot_mask;
            case ({freeze, slot_done})
                2'b10:   occ_q <= occ_q + (SLOT_W+1)'(1);
                2'b01:   occ_q <= occ_q - (SLOT_W+1)'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign wr_slot  = wr_slot_q;
    assign rd_slot  = rd_slot_q;
    assign rd_start = start_q[rd_slot_q];
    assign occ      = occ_q;
    assign full     = (occ_q == n_slots);
    assign empty    = (occ_q == '0);

    // R11: the occupancy never passes the slot count
    assert_occ_bounded_R11: assert property (@(posedge clk) disable iff (rst)
        occ_q <= n_slots);

    // R9: no event is frozen while every slot is taken
    assert_no_freeze_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        full |-> !freeze);

    // R10: nothing is released when nothing is stored
    assert_no_release_when_empty_R10: assert property (@(posedge clk) disable iff (rst)
        empty |-> !slot_done);

    // R10: the occupancy moves by at most one per cycle
    assert_occ_step_R10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((occ_q == $past(occ_q)) || (occ_q == $past(occ_q) + (SLOT_W+1)'(1))
               || (occ_q == $past(occ_q) - (SLOT_W+1)'(1))));
endmodule

// File: rtl/acq_rd_ctrl.sv
module acq_rd_ctrl
    import acq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SLOT_W  = 3,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               empty,
    input  logic [SLOT_W-1:0]  rd_slot,
    input  logic [ADDR_W-1:0]  rd_start,
    input  logic [ADDR_W-1:0]  off_mask,
    input  logic [SHIFT_W-1:0] shift,
    output logic               ram_re,
    output logic [ADDR_W-1:0]  ram_raddr,
    output logic               slot_done,
    output acq_rd_flag_t       flag
);
    logic [ADDR_W-1:0] rd_cnt_q;
    logic [ADDR_W-1:0] off;
    logic              rd_take;
    logic              at_end;

    always_comb begin
        rd_take   = rd_en && !empty;
        at_end    = (rd_cnt_q == off_mask);
        off       = (rd_start + rd_cnt_q) & off_mask;
        ram_re    = rd_take;
        ram_raddr = (ADDR_W'(rd_slot) << shift) | off;
        slot_done = rd_take && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt_q <= '0;
            flag     <= '0;
        end else begin
            flag.valid <= rd_take;
            flag.last  <= rd_take && at_end;
            if (rd_take) rd_cnt_q <= at_end ? '0 : (rd_cnt_q + ADDR_W'(1));
        end
    end

    // R6: the slot-end marker only comes with a word
    assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
        flag.last |-> flag.valid);

    // R7: with nothing stored, the read position rests at a slot start
    assert_idle_pointer_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
        empty |-> (rd_cnt_q == '0));
endmodule

// File: rtl/acq_event_buffer.sv
module acq_event_buffer
    import acq_pkg::*;
#(
    parameter int DATA_W         = 10,
    parameter int ADDR_W         = 8,
    parameter int SLOTS_LOG2_MAX = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [$clog2(SLOTS_LOG2_MAX+1)-1:0]   cfg_slots_log2,
    input  logic [ADDR_W-1:0]                     cfg_post_len,
    input  logic                                  smp_valid,
    input  logic [DATA_W-1:0]                     smp_data,
    input  logic                                  trig,
    input  logic                                  rd_en,
    output logic                                  rd_valid,
    output logic [DATA_W-1:0]                     rd_data,
    output logic                                  rd_last,
    output logic                                  full,
    output logic                                  empty,
    output logic [SLOTS_LOG2_MAX:0]               occupancy
);
    localparam int SLOT_W  = SLOTS_LOG2_MAX;
    localparam int SHIFT_W = $clog2(ADDR_W + 1);

    logic [SLOT_W:0]    n_slots;
    logic [SLOT_W-1:0]  slot_mask;
    logic [SHIFT_W-1:0] shift;
    logic [ADDR_W-1:0]  off_mask;

    logic               ram_we;
    logic [ADDR_W-1:0]  ram_waddr;
    logic               ram_re;
    logic [ADDR_W-1:0]  ram_raddr;
    logic               freeze;
    logic [ADDR_W-1:0]  freeze_off;
    logic               slot_done;
    logic [SLOT_W-1:0]  wr_slot;
    logic [SLOT_W-1:0]  rd_slot;
    logic [ADDR_W-1:0]  rd_start;
    acq_rd_flag_t       flag;

    assign n_slots   = (SLOT_W+1)'(1) << cfg_slots_log2;
    assign slot_mask = SLOT_W'(n_slots - (SLOT_W+1)'(1));
    assign shift     = SHIFT_W'(ADDR_W) - SHIFT_W'(cfg_slots_log2);
    assign off_mask  = (ADDR_W'(1) << shift) - ADDR_W'(1);

    acq_wr_ctrl #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SHIFT_W(SHIFT_W)) u_wr (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .trig(trig), .full(full),
        .post_len(cfg_post_len), .off_mask(off_mask), .shift(shift),
        .wr_slot(wr_slot), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .freeze(freeze), .freeze_off(freeze_off)
    );

    acq_slot_ring #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ring (
        .clk(clk), .rst(rst), .n_slots(n_slots), .slot_mask(slot_mask),
        .freeze(freeze), .freeze_off(freeze_off), .slot_done(slot_done),
        .wr_slot(wr_slot), .rd_slot(rd_slot), .rd_start(rd_start),
        .occ(occupancy), .full(full), .empty(empty)
    );

    acq_rd_ctrl #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SHIFT_W(SHIFT_W)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .empty(empty), .rd_slot(rd_slot),
        .rd_start(rd_start), .off_mask(off_mask), .shift(shift),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .slot_done(slot_done), .flag(flag)
    );

    acq_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(smp_data),
        .re(ram_re), .raddr(ram_raddr), .rdata(rd_data)
    );

    assign rd_valid = flag.valid;
    assign rd_last  = flag.last;
endmodule

// File: tb/acq_event_buffer_bench.sv
`timescale 1ns/1ps
module acq_event_buffer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_slots_log2 = 2'd2;
    logic [7:0] cfg_post_len = 8'd0;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_data = '0;
    logic       trig = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_valid;
    logic [9:0] rd_data;
    logic       rd_last;
    logic       full;
    logic       empty;
    logic [3:0] occupancy;

    int checks = 0;
    int failures = 0;
    int sidx = 0;
    int n_slots_m, size_m, post_m;
    int occ_m, rd_pos, rem;
    bit posting;
    int win[$];
    int exp_q[$];

    always #10 clk = ~clk;

    acq_event_buffer u_acq_event_buffer (
        .clk(clk), .rst(rst), .cfg_slots_log2(cfg_slots_log2), .cfg_post_len(cfg_post_len),
        .smp_valid(smp_valid), .smp_data(smp_data), .trig(trig), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .full(full), .empty(empty), .occupancy(occupancy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int lg, input int post);
        @(negedge clk);
        rst = 1'b1; smp_valid = 0; trig = 0; rd_en = 0;
        cfg_slots_log2 = 2'(lg); cfg_post_len = 8'(post);
        n_slots_m = 1 << lg; size_m = 256 >> lg; post_m = post;
        occ_m = 0; rd_pos = 0; rem = 0; posting = 0;
        win.delete(); exp_q.delete();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one cycle of stimulus plus the reference model of R2..R11
    task automatic step(input bit v, input bit t, input bit r);
        bit frz, done, exp_v, exp_l, full_m;
        int exp_d, pad;
        @(negedge clk);
        smp_valid = v; trig = t; rd_en = r; smp_data = 10'(sidx);
        frz = 0; done = 0; exp_v = 0; exp_l = 0; exp_d = -1;
        full_m = (occ_m == n_slots_m);
        if (v && !full_m) begin
            win.push_back(sidx & 1023);
            if (win.size() > size_m) void'(win.pop_front());
        end
        if (!posting && t && !full_m) begin
            if (post_m == 0) frz = 1;
            else begin posting = 1; rem = post_m; end
        end else if (posting && v) begin
            rem--;
            if (rem == 0) begin frz = 1; posting = 0; end
        end
        if (v) sidx++;
        if (r && occ_m > 0) begin
            exp_v = 1;
            exp_d = exp_q.pop_front();
            exp_l = (rd_pos == size_m - 1);
            rd_pos = exp_l ? 0 : rd_pos + 1;
            done = exp_l;
        end
        if (frz) begin
            pad = size_m - win.size();
            for (int i = 0; i < pad; i++) exp_q.push_back(-1);
            foreach (win[i]) exp_q.push_back(win[i]);
            win.delete();
        end
        occ_m = occ_m + int'(frz) - int'(done);
        @(posedge clk);
        #2;
        chk(rd_valid == exp_v, "R7 rd_valid", rd_valid, exp_v);
        if (exp_v) begin
            if (exp_d >= 0) chk(int'(rd_data) == exp_d, "R2 rd_data", rd_data, exp_d);
            chk(rd_last == exp_l, "R6 rd_last", rd_last, exp_l);
        end
        chk(int'(occupancy) == occ_m, "R11 occupancy", occupancy, occ_m);
        chk(full == (occ_m == n_slots_m), "R9 full", full, occ_m == n_slots_m);
        chk(empty == (occ_m == 0), "R7 empty", empty, occ_m == 0);
    endtask

    task automatic stream(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0);
    endtask

    task automatic drain();
        while (occ_m > 0) step(0, 0, 1);
    endtask

    task automatic t_reset();
        do_reset(2, 10);
        chk(empty == 1'b1, "R1 empty", empty, 1);
        chk(full == 1'b0, "R1 full", full, 0);
        chk(occupancy == 4'd0, "R1 occupancy", occupancy, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    endtask

    task automatic t_single_event();
        do_reset(2, 10);
        stream(80);
        step(1, 1, 0);
        stream(9);
        chk(occupancy == 4'd0, "R3 not frozen before last post sample", occupancy, 0);
        step(1, 0, 0);
        chk(occupancy == 4'd1, "R3 frozen on last post sample", occupancy, 1);
        stream(20);
        drain();
    endtask

    task automatic t_post_zero();
        do_reset(2, 0);
        stream(70);
        step(1, 1, 0);
        chk(occupancy == 4'd1, "R3 post length zero freezes at trigger", occupancy, 1);
        drain();
    endtask

    task automatic t_retrigger();
        do_reset(2, 20);
        stream(70);
        step(1, 1, 0);
        for (int i = 0; i < 40; i++) step(i[0], 1, 0);
        chk(occupancy == 4'd1, "R8 retrigger ignored", occupancy, 1);
        stream(5);
        drain();
    endtask

    task automatic t_back_to_back();
        do_reset(2, 5);
        stream(70);
        step(1, 1, 0);
        stream(5);
        step(1, 1, 0);
        stream(5);
        chk(occupancy == 4'd2, "R4 back-to-back events", occupancy, 2);
        drain();
    endtask

    task automatic t_fill_full();
        do_reset(2, 3);
        for (int e = 0; e < 4; e++) begin
            stream(70);
            step(1, 1, 0);
            stream(3);
        end
        chk(full == 1'b1, "R9 full after all slots frozen", full, 1);
        for (int i = 0; i < 30; i++) step(1, 1, 0);
        chk(occupancy == 4'd4, "R9 triggers ignored while full", occupancy, 4);
        for (int i = 0; i < 63; i++) step(0, 0, 1);
        chk(occupancy == 4'd4, "R10 slot held until last word", occupancy, 4);
        step(0, 0, 1);
        chk(occupancy == 4'd3, "R10 slot released on last word", occupancy, 3);
        stream(70);
        step(1, 1, 0);
        stream(3);
        chk(full == 1'b1, "R9 resumed slot refilled", full, 1);
        drain();
    endtask

    task automatic t_concurrent();
        do_reset(1, 30);
        stream(140);
        step(1, 1, 0);
        stream(30);
        for (int i = 0; i < 128; i++) step(1, i == 100, 1);
        for (int i = 0; i < 40; i++) step(1, 0, 1);
        chk(occupancy == 4'd1, "R5 second event frozen during readout", occupancy, 1);
        drain();
    endtask

    task automatic t_slot_counts();
        do_reset(0, 8);
        stream(260);
        step(1, 1, 0);
        stream(8);
        chk(full == 1'b1, "R5 single slot full", full, 1);
        drain();
        do_reset(3, 4);
        for (int e = 0; e < 8; e++) begin
            stream(40);
            step(1, 1, 0);
            stream(4);
        end
        chk(occupancy == 4'd8, "R5 eight slots", occupancy, 8);
        drain();
    endtask

    task automatic t_empty_read();
        do_reset(2, 10);
        for (int i = 0; i < 5; i++) step(1, 0, 1);
        chk(rd_valid == 1'b0, "R7 read while empty ignored", rd_valid, 0);
        stream(70);
        step(1, 1, 0);
        stream(10);
        drain();
    endtask

    initial begin
        t_reset();
        t_single_event();
        t_post_zero();
        t_retrigger();
        t_back_to_back();
        t_fill_full();
        t_concurrent();
        t_slot_counts();
        t_empty_read();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule